// File: doc/BRIEF.md
# Nibble I/O Port Pair with Instruction-Steered Direction

This block sits next to a small 4-bit processor and owns two 4-bit general-purpose pin groups. It takes an already decoded port operation each cycle (an operation code, a port select and a 4-bit argument). From these it keeps the output latches and the pin direction state, and it gates the pad inputs. In the same cycle it returns the read data and a skip flag for the conditional-test operations.

Port E has no direction register that software writes. Its whole nibble becomes an input after any input-type operation (read, test-true, test-false). It becomes an output after any output-type operation (write, set-bits, clear-bits), and it stays in that mode until an operation of the other kind arrives. Port F keeps a per-pin direction register, which only the dedicated direction-load operation changes. Reset and low-power backup put every pin in input mode. Backup also blocks the pad inputs and suspends all operations.

Top module: `nib_port_ctrl`

## Requirements
- R1: While `rst_n` is low, all output enables are 0 and both output latches are cleared to 0000.
- R2: A read (op 1), test-true (op 5) or test-false (op 6) with `port_sel_i`=0 puts all four port E pins in input mode (`pad_e_oe_o`=0000) from the next cycle. They stay in that mode until an output-type operation on port E.
- R3: A write (op 2), set-bits (op 3) or clear-bits (op 4) with `port_sel_i`=0 puts all four port E pins in output mode (`pad_e_oe_o`=1111) from the next cycle. They stay in that mode until an input-type operation on port E.
- R4: A write loads `op_arg_i` into the selected port's output latch whatever the current direction. The latch keeps its value across direction changes, and `pad_e_o`/`pad_f_o` always show the latch.
- R5: Set-bits makes latch ← latch OR `op_arg_i`.
- R6: Clear-bits makes latch ← latch AND NOT `op_arg_i`.
- R7: Direction-load (op 7, `port_sel_i` ignored) loads `op_arg_i` into the port F direction register. Bit i = 1 makes pin i an output, and `pad_f_oe_o` equals that register. No other operation changes it.
- R8: In the cycle of a test, with v the read view of the selected port and m = `op_arg_i`, `skip_o` is 1. For test-true this requires (v AND m) = m; for test-false it requires (v AND m) = 0. An empty mask therefore skips. For every other operation `skip_o` is 0.
- R9: `rd_data_o` is combinational in the cycle of the operation. For port E it is the gated pad input. For port F, pin i shows the latch bit when that pin is an output and the gated pad bit otherwise. Op 0 is a no-op.
- R10: While `backup_i` is 1, all output enables are 0, the gated inputs read 0000, `rd_data_o` and `skip_o` are 0, and operations are ignored with both latches unchanged. Port E direction and the port F direction register are cleared to input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup_i | input | 1 | Low-power backup mode |
| op_code_i | input | 3 | Operation: 0 nop, 1 read, 2 write, 3 set, 4 clear, 5 test-true, 6 test-false, 7 F direction load |
| port_sel_i | input | 1 | 0 = port E, 1 = port F |
| op_arg_i | input | 4 | Write data, bit mask or direction value |
| pad_e_i | input | 4 | Port E pad input levels |
| pad_f_i | input | 4 | Port F pad input levels |
| pad_e_o | output | 4 | Port E output latch |
| pad_e_oe_o | output | 4 | Port E output enables |
| pad_f_o | output | 4 | Port F output latch |
| pad_f_oe_o | output | 4 | Port F output enables |
| rd_data_o | output | 4 | Read view of the selected port |
| skip_o | output | 1 | Test result (skip next instruction) |

## Verification
A port E output-type operation issued while the port is an input changes both the latch and the direction at one edge. The bench provokes this by alternating reads and writes on port E through an exhaustive sweep. It then checks that the pins drive the newly written value in the next cycle, and not the value held before. Backup can also coincide with an operation. Such steps are placed inside the sweep, and the bench judges them by seeing unchanged latches at the output pins and every enable at 0.

// File: rtl/nport_pkg.sv
package nport_pkg;
  localparam int NIB_W = 4;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_SETB = 3'd3,
    OP_CLRB = 3'd4,
    OP_TSTT = 3'd5,
    OP_TSTF = 3'd6,
    OP_FDIR = 3'd7
  } port_op_e;

  typedef logic [NIB_W-1:0] nib_t;

  function automatic logic is_input_op(port_op_e op);
    return (op == OP_RD) || (op == OP_TSTT) || (op == OP_TSTF);
  endfunction

  function automatic logic is_output_op(port_op_e op);
    return (op == OP_WR) || (op == OP_SETB) || (op == OP_CLRB);
  endfunction

  function automatic nib_t latch_next(port_op_e op, nib_t cur, nib_t arg);
    case (op)
      OP_WR:   return arg;
      OP_SETB: return cur | arg;
      OP_CLRB: return cur & ~arg;
      default: return cur;
    endcase
  endfunction

  function automatic logic mask_all_ones(nib_t v, nib_t m);
    return (v & m) == m;
  endfunction

  function automatic logic mask_all_zeros(nib_t v, nib_t m);
    return (v & m) == '0;
  endfunction
endpackage

// File: rtl/nport_in_gate.sv
module nport_in_gate
  import nport_pkg::*;
(
  input  logic       backup_i,
  input  nib_t       pad_i,
  output nib_t       samp_o
);
  for (genvar i = 0; i < NIB_W; i++) begin : g_pin
    assign samp_o[i] = pad_i[i] & ~backup_i;
  end
endmodule

// File: rtl/nport_implicit.sv
module nport_implicit
  import nport_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     backup_i,
  input  logic     fire_i,
  input  port_op_e op_i,
  input  nib_t     arg_i,
  output nib_t     lat_o,
  output logic     drive_o
);
  nib_t lat_q;
  logic drv_q;
  wire  go_in  = fire_i & is_input_op(op_i);
  wire  go_out = fire_i & is_output_op(op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      drv_q <= 1'b0;
    end else if (backup_i) begin
      drv_q <= 1'b0;
    end else begin
      if (go_out) lat_q <= latch_next(op_i, lat_q, arg_i);
      if (go_in)       drv_q <= 1'b0;
      else if (go_out) drv_q <= 1'b1;
    end
  end

  assign lat_o   = lat_q;
  assign drive_o = drv_q;

  a_r2_input_after_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    (go_in && !backup_i) |=> !drive_o);
  a_r3_output_after_out_op: assert property (@(posedge clk) disable iff (!rst_n)
    (go_out && !backup_i) |=> drive_o);
  a_r4_latch_kept_on_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_out) |=> $stable(lat_o));
  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (go_out && op_i == OP_SETB && !backup_i) |=> lat_o == ($past(lat_o) | $past(arg_i)));
  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (go_out && op_i == OP_CLRB && !backup_i) |=> lat_o == ($past(lat_o) & ~$past(arg_i)));
  a_r10_backup_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |=> ($stable(lat_o) && !drive_o));
endmodule

// File: rtl/nport_explicit.sv
module nport_explicit
  import nport_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     backup_i,
  input  logic     fire_i,
  input  logic     dir_load_i,
  input  port_op_e op_i,
  input  nib_t     arg_i,
  output nib_t     lat_o,
  output nib_t     dir_o
);
  nib_t lat_q;
  nib_t dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else if (backup_i) begin
      dir_q <= '0;
    end else begin
      if (fire_i)     lat_q <= latch_next(op_i, lat_q, arg_i);
      if (dir_load_i) dir_q <= arg_i;
    end
  end

  assign lat_o = lat_q;
  assign dir_o = dir_q;

  a_r7_dir_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_load_i && !backup_i) |=> $stable(dir_o));
  a_r7_dir_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_load_i && !backup_i) |=> dir_o == $past(arg_i));
  a_r10_backup_clears_dir: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |=> (dir_o == '0 && $stable(lat_o)));
endmodule

// File: rtl/nport_resp.sv
module nport_resp
  import nport_pkg::*;
(
  input  logic     backup_i,
  input  port_op_e op_i,
  input  logic     sel_f_i,
  input  nib_t     e_samp_i,
  input  nib_t     f_samp_i,
  input  nib_t     f_lat_i,
  input  nib_t     f_dir_i,
  input  nib_t     mask_i,
  output nib_t     rd_o,
  output logic     skip_o
);
  nib_t f_view;
  nib_t view;

  always_comb begin
    f_view = (f_dir_i & f_lat_i) | (~f_dir_i & f_samp_i);
    view   = backup_i ? '0 : (sel_f_i ? f_view : e_samp_i);
    skip_o = 1'b0;
    if (!backup_i) begin
      if (op_i == OP_TSTT) skip_o = mask_all_ones(view, mask_i);
      if (op_i == OP_TSTF) skip_o = mask_all_zeros(view, mask_i);
    end
  end

  assign rd_o = view;
endmodule

// File: rtl/nib_port_ctrl.sv
module nib_port_ctrl
  import nport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       backup_i,
  input  logic [2:0] op_code_i,
  input  logic       port_sel_i,
  input  logic [3:0] op_arg_i,
  input  logic [3:0] pad_e_i,
  input  logic [3:0] pad_f_i,
  output logic [3:0] pad_e_o,
  output logic [3:0] pad_e_oe_o,
  output logic [3:0] pad_f_o,
  output logic [3:0] pad_f_oe_o,
  output logic [3:0] rd_data_o,
  output logic       skip_o
);
  port_op_e op;
  nib_t e_samp, f_samp, e_lat, f_lat, f_dir;
  logic e_drive;

  assign op = port_op_e'(op_code_i);

  wire op_go    = ~backup_i;
  wire e_fire   = op_go & ~port_sel_i & (op != OP_FDIR);
  wire f_fire   = op_go &  port_sel_i & (op != OP_FDIR);
  wire dir_load = op_go & (op == OP_FDIR);

  nport_in_gate u_gate_e (.backup_i(backup_i), .pad_i(pad_e_i), .samp_o(e_samp));
  nport_in_gate u_gate_f (.backup_i(backup_i), .pad_i(pad_f_i), .samp_o(f_samp));

  nport_implicit u_port_e (
    .clk(clk), .rst_n(rst_n), .backup_i(backup_i), .fire_i(e_fire),
    .op_i(op), .arg_i(op_arg_i), .lat_o(e_lat), .drive_o(e_drive));

  nport_explicit u_port_f (
    .clk(clk), .rst_n(rst_n), .backup_i(backup_i), .fire_i(f_fire),
    .dir_load_i(dir_load), .op_i(op), .arg_i(op_arg_i),
    .lat_o(f_lat), .dir_o(f_dir));

  nport_resp u_resp (
    .backup_i(backup_i), .op_i(op), .sel_f_i(port_sel_i),
    .e_samp_i(e_samp), .f_samp_i(f_samp), .f_lat_i(f_lat), .f_dir_i(f_dir),
    .mask_i(op_arg_i), .rd_o(rd_data_o), .skip_o(skip_o));

  assign pad_e_o    = e_lat;
  assign pad_f_o    = f_lat;
  assign pad_e_oe_o = {NIB_W{e_drive & ~backup_i}};
  assign pad_f_oe_o = f_dir & {NIB_W{~backup_i}};

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_inputs: assert (pad_e_oe_o == '0 && pad_f_oe_o == '0 && e_lat == '0 && f_lat == '0);
    end
  end

  a_r8_skip_only_on_test: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (op == OP_TSTT || op == OP_TSTF));
  a_r10_backup_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    backup_i |-> (rd_data_o == '0 && !skip_o));
  a_r9_write_pin_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (!backup_i && port_sel_i && op == OP_RD && f_dir == 4'hF) |-> rd_data_o == pad_f_o);
endmodule

// File: tb/sim_nib_port_ctrl.sv
module sim_nib_port_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic backup = 1'b0;
  logic [2:0] op = 3'd0;
  logic sel = 1'b0;
  logic [3:0] arg = 4'd0, pe = 4'd0, pf = 4'd0;
  logic [3:0] eo, eoe, fo, foe, rd;
  logic skip;

  int n_chk = 0, n_fail = 0;

  logic [3:0] m_elat = 0, m_flat = 0, m_fdir = 0;
  logic       m_edir = 0;

  always #10 clk = ~clk;

  nib_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .backup_i(backup), .op_code_i(op),
    .port_sel_i(sel), .op_arg_i(arg), .pad_e_i(pe), .pad_f_i(pf),
    .pad_e_o(eo), .pad_e_oe_o(eoe), .pad_f_o(fo), .pad_f_oe_o(foe),
    .rd_data_o(rd), .skip_o(skip));

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_pins(input string req);
    chk(req, "pad_e_o", eo, m_elat);
    chk(req, "pad_e_oe", eoe, (m_edir && !backup) ? 4'hF : 4'h0);
    chk(req, "pad_f_o", fo, m_flat);
    chk(req, "pad_f_oe", foe, backup ? 4'h0 : m_fdir);
  endtask

  task automatic step(input logic bk, input logic [2:0] o, input logic s,
                      input logic [3:0] a, input logic [3:0] e_in, input logic [3:0] f_in);
    logic [3:0] ge, gf, view;
    logic       xs;
    string      rq;
    @(negedge clk);
    backup = bk; op = o; sel = s; arg = a; pe = e_in; pf = f_in;
    #2;
    ge = bk ? 4'h0 : e_in;
    gf = bk ? 4'h0 : f_in;
    view = bk ? 4'h0 : (s ? ((m_fdir & m_flat) | (~m_fdir & gf)) : ge);
    xs = 1'b0;
    if (!bk && o == 3'd5) xs = ((view & a) == a);
    if (!bk && o == 3'd6) xs = ((view & a) == 4'h0);
    chk(bk ? "R10" : "R9", "rd_data", rd, view);
    chk((o == 3'd5 || o == 3'd6) ? "R8" : "R8_other", "skip", {3'b0, skip}, {3'b0, xs});
    if (bk) begin
      m_edir = 0; m_fdir = 0; rq = "R10";
    end else begin
      case (o)
        3'd1, 3'd5, 3'd6: begin if (!s) m_edir = 0; rq = "R2"; end
        3'd2: begin if (s) m_flat = a; else begin m_elat = a; m_edir = 1; end rq = "R4"; end
        3'd3: begin if (s) m_flat |= a; else begin m_elat |= a; m_edir = 1; end rq = "R5"; end
        3'd4: begin if (s) m_flat &= ~a; else begin m_elat &= ~a; m_edir = 1; end rq = "R6"; end
        3'd7: begin m_fdir = a; rq = "R7"; end
        default: rq = "R9";
      endcase
      if (!s && (o == 3'd2 || o == 3'd3 || o == 3'd4)) rq = "R3";
    end
    @(posedge clk);
    #2;
    backup = 0;
    chk_pins(rq);
  endtask

  initial begin
    #10000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] pat [4] = '{4'h0, 4'hF, 4'h5, 4'hC};
    repeat (3) @(negedge clk);
    chk("R1", "reset e_oe", eoe, 4'h0);
    chk("R1", "reset f_oe", foe, 4'h0);
    chk("R1", "reset e_lat", eo, 4'h0);
    chk("R1", "reset f_lat", fo, 4'h0);
    rst_n = 1;

    // R4: write while input, read keeps latch, write again drives new data
    step(0, 3'd2, 0, 4'hA, 4'h3, 4'h0);
    step(0, 3'd1, 0, 4'h0, 4'h6, 4'h0);
    chk("R4", "latch kept in input", eo, 4'hA);
    step(0, 3'd3, 0, 4'h1, 4'h6, 4'h0);
    chk("R3", "back to output drives", eo, 4'hB);
    // R10 directed: backup with a write
    step(1, 3'd2, 0, 4'h0, 4'hF, 4'hF);
    chk("R10", "latch frozen", eo, 4'hB);
    chk("R10", "e input after backup", eoe, 4'h0);

    for (int pp = 0; pp < 4; pp++) begin
      for (int o = 0; o < 8; o++) begin
        for (int s = 0; s < 2; s++) begin
          for (int a = 0; a < 16; a++) begin
            step((a == 9) && pp[0], 3'(o), 1'(s), 4'(a),
                 4'(a) ^ pat[pp], ~(4'(a)) ^ pat[3-pp]);
            step(0, 3'd1, 0, 4'(a), pat[pp], 4'(a));
            step(0, 3'(o), 1'(s), ~(4'(a)), 4'(a), pat[pp]);
          end
        end
      end
      if (pp == 1) begin
        @(negedge clk);
        rst_n = 0;
        m_elat = 0; m_flat = 0; m_fdir = 0; m_edir = 0;
        #2;
        chk_pins("R1");
        @(negedge clk);
        rst_n = 1;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule